// File: doc/BRIEF.md
# Double to Int32 Wrapping Converter

This unit turns an IEEE-754 binary64 operand into a 32-bit signed integer the way scripting-language number semantics expect. The value is truncated toward zero, and when the integer does not fit in 32 bits the low 32 bits of its two's-complement form are returned instead of a clamped value. Infinity and NaN both give zero. The unit reports exactness through a Z-style bit that is set only when the conversion lost nothing. Negative zero is treated as inexact.

Alongside the result the unit emits one-cycle exception pulses for inexact, invalid and input-denormal. A flush-inputs-to-zero mode bit changes how subnormal operands are reported. In the default build the result is registered: it appears one clock after the input strobe and stays put until the next strobe. A parameter selects a purely combinational variant instead.

Top module: `dbl_wrap_cvt`

## Requirements
- R1: The operand is split into sign (bit 63), biased exponent (bits 62..52) and fraction (bits 51..0). A normal operand whose truncated integer lies in −2^31..2^31−1 returns that integer truncated toward zero.
- R2: When the truncated integer lies outside the 32-bit signed range, the result is its low 32 bits in two's complement. The result is never clamped.
- R3: An exponent field of zero with a zero fraction returns 0 and raises no flag. Z is 1 for +0 and 0 for −0.
- R4: With flush mode set, a subnormal operand returns 0 and raises only the input-denormal pulse, not the inexact pulse. Z equals the inverted sign.
- R5: With flush mode clear, a subnormal operand returns 0, raises the inexact pulse and clears Z.
- R6: An exponent field of all ones (infinity or NaN) returns 0, raises the invalid pulse and clears Z.
- R7: A normal in-range operand that has nonzero fraction bits below the binary point raises the inexact pulse and clears Z. An operand with no such bits sets Z and raises no flag.
- R8: A normal operand whose integer is out of range raises the invalid pulse instead of the inexact pulse and clears Z.
- R9: An operand with unbiased exponent 84 or more returns 0, because every significand bit lands above bit 31.
- R10: out_vld rises exactly one clock after in_vld. The result and Z hold while no strobe arrives, and operand changes without a strobe have no effect. At most one exception pulse is high, and only in an out_vld cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand |
| in_ftz | input | 1 | Flush subnormal inputs to zero |
| out_vld | output | 1 | Result strobe, one clock after in_vld |
| out_res | output | 32 | Wrapped, truncated integer |
| out_z | output | 1 | 1 when the conversion is exact |
| out_ixc | output | 1 | Inexact pulse |
| out_ioc | output | 1 | Invalid pulse |
| out_idc | output | 1 | Input-denormal pulse |

## Verification
The bench builds the block with its defaults: an 11-bit exponent, a 52-bit fraction, a 32-bit result and the registered variant. This brings the full binary64 exponent range within reach, including the boundary between 2^31−1 and 2^31, the exponent-84 cutoff and the subnormal band under both flush settings. Random operands are weighted toward exponents near the bias and toward zero exponents. They are combined with directed cases for signed zeros, infinities, NaN and the range limits. The hold and ignore behaviour is checked by changing the operand while the strobe is low.

// File: rtl/dwc_pkg.sv
`timescale 1ns/1ps
// Shared types for the double-to-int32 wrapping converter.
package dwc_pkg;

    // Operand class decided from the exponent field alone.
    typedef enum logic [1:0] {
        CLS_ZERO_SUB = 2'd0,
        CLS_NORMAL   = 2'd1,
        CLS_SPECIAL  = 2'd2
    } dwc_cls_e;

    // Exception pulses produced by one conversion.
    typedef struct packed {
        logic ixc;
        logic ioc;
        logic idc;
    } dwc_flags_t;

endpackage

// File: rtl/dwc_unpack.sv
`timescale 1ns/1ps
// dwc_unpack: splits a binary floating-point operand into sign, class,
// significand with hidden one, and unbiased exponent.
// Assumes the standard layout: sign at the top, exponent, then fraction.
module dwc_unpack
    import dwc_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]  op,
    output logic                   sign,
    output dwc_cls_e               cls,
    output logic                   frac_nz,
    output logic [FRAC_W:0]        sig,
    output logic signed [EXP_W:0]  unb_exp
);
    localparam int EW = EXP_W + 1;
    localparam logic signed [EW-1:0] BIAS = EW'((1 << (EXP_W - 1)) - 1);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Field extraction and classification.
    always_comb begin
        sign    = op[EXP_W+FRAC_W];
        exp_f   = op[EXP_W+FRAC_W-1:FRAC_W];
        frac_f  = op[FRAC_W-1:0];
        frac_nz = |frac_f;
        sig     = {1'b1, frac_f};
        unb_exp = $signed({1'b0, exp_f}) - BIAS;
        if (exp_f == '0)
            cls = CLS_ZERO_SUB;
        else if (&exp_f)
            cls = CLS_SPECIAL;
        else
            cls = CLS_NORMAL;
    end
endmodule

// File: rtl/dwc_shift.sv
`timescale 1ns/1ps
// dwc_shift: positions the significand by the unbiased exponent and keeps
// the low OUT_W bits of the truncated integer magnitude.
// It reports whether any fraction bit was dropped, and whether the
// magnitude reaches 2^OUT_W or more.
// Assumes FRAC_W+1 >= OUT_W. A left shift of OUT_W or more gives zero and
// never wraps its shift amount.
module dwc_shift #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int OUT_W  = 32
) (
    input  logic [FRAC_W:0]        sig,
    input  logic signed [EXP_W:0]  unb_exp,
    output logic [OUT_W-1:0]       mag_low,
    output logic                   lost,
    output logic                   big
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int EW    = EXP_W + 1;
    localparam logic signed [EW-1:0] E_FRAC = EW'(FRAC_W);
    localparam logic signed [EW-1:0] E_OUT  = EW'(OUT_W);
    localparam logic signed [EW-1:0] E_ZERO = '0;

    logic [EW-1:0]        rsh;
    logic signed [EW-1:0] lsh;
    logic [SIG_W-1:0]     int_full;

    // Right shift for small exponents, left shift for large ones.
    always_comb begin
        rsh      = E_FRAC - unb_exp;
        lsh      = unb_exp - E_FRAC;
        int_full = '0;
        mag_low  = '0;
        lost     = 1'b0;
        big      = 1'b0;
        if (unb_exp < E_ZERO) begin
            lost = 1'b1;
        end else if (unb_exp <= E_FRAC) begin
            int_full = sig >> rsh;
            mag_low  = int_full[OUT_W-1:0];
            lost     = |(sig & ~({SIG_W{1'b1}} << rsh));
            big      = |int_full[SIG_W-1:OUT_W];
        end else begin
            big = 1'b1;
            if (lsh < E_OUT)
                mag_low = sig[OUT_W-1:0] << lsh;
        end
    end
endmodule

// File: rtl/dwc_resolve.sv
`timescale 1ns/1ps
// dwc_resolve: combines class, sign and shifted magnitude into the wrapped
// result, the exactness bit and the exception flags.
// Assumes that when big is clear, mag_low is the whole magnitude.
module dwc_resolve
    import dwc_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  dwc_cls_e          cls,
    input  logic              sign,
    input  logic              frac_nz,
    input  logic              ftz,
    input  logic [OUT_W-1:0]  mag_low,
    input  logic              lost,
    input  logic              big,
    output logic [OUT_W-1:0]  res,
    output logic              z,
    output dwc_flags_t        flags
);
    logic ovf;
    logic inexact;

    // Range test, signed wrap and flag priority for each class.
    always_comb begin
        ovf     = big | (sign ? (mag_low[OUT_W-1] & (|mag_low[OUT_W-2:0]))
                              : mag_low[OUT_W-1]);
        res     = '0;
        flags   = '0;
        inexact = 1'b0;
        unique case (cls)
            CLS_ZERO_SUB: begin
                inexact = sign;
                if (frac_nz) begin
                    if (ftz) begin
                        flags.idc = 1'b1;
                    end else begin
                        flags.ixc = 1'b1;
                        inexact   = 1'b1;
                    end
                end
            end
            CLS_SPECIAL: begin
                flags.ioc = 1'b1;
                inexact   = 1'b1;
            end
            default: begin
                res = sign ? -mag_low : mag_low;
                if (ovf) begin
                    flags.ioc = 1'b1;
                    inexact   = 1'b1;
                end else if (lost) begin
                    flags.ixc = 1'b1;
                    inexact   = 1'b1;
                end
            end
        endcase
        z = ~inexact;
    end
endmodule

// File: rtl/dbl_wrap_cvt.sv
`timescale 1ns/1ps
// dbl_wrap_cvt: binary64 to 32-bit signed integer, truncating toward zero
// and wrapping modulo 2^OUT_W. It gives an exactness bit and exception pulses.
// Assumes in_op is stable while in_vld is high. With REGISTERED=1 the
// outputs appear one clock later and hold between strobes.
module dbl_wrap_cvt
    import dwc_pkg::*;
#(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter int OUT_W      = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [EXP_W+FRAC_W:0]   in_op,
    input  logic                    in_ftz,
    output logic                    out_vld,
    output logic [OUT_W-1:0]        out_res,
    output logic                    out_z,
    output logic                    out_ixc,
    output logic                    out_ioc,
    output logic                    out_idc
);
    localparam int OP_W = EXP_W + FRAC_W + 1;

    logic                   sign;
    dwc_cls_e               cls;
    logic                   frac_nz;
    logic [FRAC_W:0]        sig;
    logic signed [EXP_W:0]  unb_exp;
    logic [OUT_W-1:0]       mag_low;
    logic                   lost;
    logic                   big;
    logic [OUT_W-1:0]       c_res;
    logic                   c_z;
    dwc_flags_t             c_flags;

    dwc_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .op(in_op), .sign(sign), .cls(cls), .frac_nz(frac_nz),
        .sig(sig), .unb_exp(unb_exp)
    );

    dwc_shift #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_shift (
        .sig(sig), .unb_exp(unb_exp), .mag_low(mag_low),
        .lost(lost), .big(big)
    );

    dwc_resolve #(.OUT_W(OUT_W)) u_resolve (
        .cls(cls), .sign(sign), .frac_nz(frac_nz), .ftz(in_ftz),
        .mag_low(mag_low), .lost(lost), .big(big),
        .res(c_res), .z(c_z), .flags(c_flags)
    );

    generate
        if (REGISTERED) begin : g_reg
            // Capture on strobe; results hold, flags pulse for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_vld <= 1'b0;
                    out_res <= '0;
                    out_z   <= 1'b0;
                    out_ixc <= 1'b0;
                    out_ioc <= 1'b0;
                    out_idc <= 1'b0;
                end else begin
                    out_vld <= in_vld;
                    out_ixc <= in_vld & c_flags.ixc;
                    out_ioc <= in_vld & c_flags.ioc;
                    out_idc <= in_vld & c_flags.idc;
                    if (in_vld) begin
                        out_res <= c_res;
                        out_z   <= c_z;
                    end
                end
            end

            // R10: output strobe follows input strobe by one clock.
            p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
                in_vld |=> out_vld);

            // R10: without a strobe nothing moves and no flag pulses.
            p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_vld |=> (!out_vld && $stable(out_res) && $stable(out_z)
                             && !out_ixc && !out_ioc && !out_idc));

            // R6: infinity and NaN give zero with invalid raised.
            p_special_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && (&in_op[OP_W-2:FRAC_W]))
                |=> (out_res == '0 && out_ioc && !out_z));

            // R4: flushed subnormal raises only the denormal pulse.
            p_ftz_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_vld && in_ftz && in_op[OP_W-2:FRAC_W] == '0
                 && in_op[FRAC_W-1:0] != '0)
                |=> (out_idc && !out_ixc && out_res == '0));
        end else begin : g_comb
            // Pass-through variant; flags gated by the strobe.
            always_comb begin
                out_vld = in_vld;
                out_res = c_res;
                out_z   = c_z;
                out_ixc = in_vld & c_flags.ixc;
                out_ioc = in_vld & c_flags.ioc;
                out_idc = in_vld & c_flags.idc;
            end
        end
    endgenerate

    // R10: at most one exception pulse at a time.
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_ixc, out_ioc, out_idc}));

    // R7: any inexact or invalid pulse means Z is clear.
    p_flag_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ixc || out_ioc) |-> !out_z);

    // R10: flags appear only alongside a result strobe.
    p_flag_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ixc || out_ioc || out_idc) |-> out_vld);
endmodule

// File: tb/dbl_wrap_cvt_tb.sv
`timescale 1ns/1ps
module dbl_wrap_cvt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [63:0] in_op = '0;
    logic        in_ftz = 1'b0;
    logic        out_vld;
    logic [31:0] out_res;
    logic        out_z, out_ixc, out_ioc, out_idc;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbl_wrap_cvt u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_ftz(in_ftz), .out_vld(out_vld), .out_res(out_res),
        .out_z(out_z), .out_ixc(out_ixc), .out_ioc(out_ioc),
        .out_idc(out_idc)
    );

    // Reference model written from the requirements with wide arithmetic.
    function automatic void model(input logic [63:0] op, input logic ftz,
                                  output logic [31:0] res, output logic z,
                                  output logic ixc, output logic ioc,
                                  output logic idc);
        logic        s;
        logic [10:0] e;
        logic [51:0] f;
        logic [139:0] w;
        logic [87:0] ip;
        logic        ovf;
        int          ue;
        s = op[63]; e = op[62:52]; f = op[51:0];
        res = '0; z = 1'b1; ixc = 1'b0; ioc = 1'b0; idc = 1'b0;
        if (e == 11'd0) begin
            if (f != '0) begin
                if (ftz) begin idc = 1'b1; z = ~s; end
                else begin ixc = 1'b1; z = 1'b0; end
            end else z = ~s;
        end else if (e == 11'h7FF) begin
            ioc = 1'b1; z = 1'b0;
        end else begin
            ue = int'(e) - 1023;
            if (ue < 0) begin
                ixc = 1'b1; z = 1'b0;
            end else if (ue > 84) begin
                ioc = 1'b1; z = 1'b0;
            end else begin
                w  = {87'b0, 1'b1, f} << ue;
                ip = w[139:52];
                ovf = s ? (ip > 88'h8000_0000) : (ip > 88'h7FFF_FFFF);
                res = s ? -ip[31:0] : ip[31:0];
                if (ovf) begin ioc = 1'b1; z = 1'b0; end
                else if (w[51:0] != '0) begin ixc = 1'b1; z = 1'b0; end
            end
        end
    endfunction

    // Requirement tag for an operand, used in messages.
    function automatic string req_of(input logic [63:0] op, input logic ftz);
        int ue;
        ue = int'(op[62:52]) - 1023;
        if (op[62:52] == 11'd0)
            return (op[51:0] == '0) ? "R3" : (ftz ? "R4" : "R5");
        if (op[62:52] == 11'h7FF) return "R6";
        if (ue >= 84) return "R9";
        if (ue >= 31) return "R8,R2";
        return "R7,R1";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One strobe, check the result cycle, then the idle cycle with a new operand.
    task automatic run(input logic [63:0] op, input logic ftz);
        logic [31:0] e_res;
        logic        e_z, e_ixc, e_ioc, e_idc;
        string       rq;
        model(op, ftz, e_res, e_z, e_ixc, e_ioc, e_idc);
        rq = req_of(op, ftz);
        @(negedge clk);
        in_op = op; in_ftz = ftz; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        in_op = {$urandom, $urandom};
        in_ftz = ~ftz;
        chk(out_vld == 1'b1, "R10", "valid after strobe", 64'(out_vld), 64'd1);
        chk(out_res == e_res, rq, $sformatf("result op=%h", op),
            64'(out_res), 64'(e_res));
        chk({out_z, out_ixc, out_ioc, out_idc} == {e_z, e_ixc, e_ioc, e_idc},
            rq, $sformatf("z/ixc/ioc/idc op=%h ftz=%0d", op, ftz),
            64'({out_z, out_ixc, out_ioc, out_idc}),
            64'({e_z, e_ixc, e_ioc, e_idc}));
        @(negedge clk);
        chk({out_vld, out_ixc, out_ioc, out_idc} == 4'b0 && out_res == e_res
            && out_z == e_z, "R10", "hold without strobe",
            64'({out_vld, out_z, out_ixc, out_ioc, out_idc, out_res}),
            64'({1'b0, e_z, 3'b000, e_res}));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({out_vld, out_z, out_ixc, out_ioc, out_idc} == 5'b0 && out_res == '0,
            "R10", "reset state",
            64'({out_vld, out_z, out_ixc, out_ioc, out_idc, out_res}), 64'd0);

        // Directed corner cases.
        run(64'h0000_0000_0000_0000, 1'b0);  // R3 +0 exact
        run(64'h8000_0000_0000_0000, 1'b0);  // R3 -0 inexact, no flag
        run(64'h0000_0000_0000_0001, 1'b1);  // R4 flushed subnormal
        run(64'h800F_FFFF_FFFF_FFFF, 1'b1);  // R4 negative flushed subnormal
        run(64'h0008_0000_0000_0000, 1'b0);  // R5 subnormal, no flush
        run(64'h7FF0_0000_0000_0000, 1'b0);  // R6 +inf
        run(64'hFFF0_0000_0000_0000, 1'b0);  // R6 -inf
        run(64'h7FF8_0000_0000_0001, 1'b0);  // R6 NaN gives zero
        run(64'h3FF0_0000_0000_0000, 1'b0);  // R1 1.0
        run(64'hBFF0_0000_0000_0000, 1'b0);  // R1 -1.0
        run(64'h3FF8_0000_0000_0000, 1'b0);  // R7 1.5 -> 1
        run(64'hC004_0000_0000_0000, 1'b0);  // R7 -2.5 -> -2
        run(64'h3FE0_0000_0000_0000, 1'b0);  // R7 0.5 -> 0
        run(64'h41DF_FFFF_FFC0_0000, 1'b0);  // R1 2^31-1 exact
        run(64'h41E0_0000_0000_0000, 1'b0);  // R8 2^31 wraps
        run(64'hC1E0_0000_0000_0000, 1'b0);  // R1 -2^31 exact
        run(64'hC1E0_0000_0020_0000, 1'b0);  // R8 -(2^31+1)
        run(64'h41F0_0000_0050_0000, 1'b0);  // R2 2^32+5 wraps to 5
        run(64'h4520_0000_0000_0001, 1'b0);  // R2 exponent 83, bit 31 left
        run(64'h4530_0000_0000_0000, 1'b0);  // R9 exponent 84 gives zero
        run(64'hC6F0_0000_0000_0001, 1'b0);  // R9 huge negative

        // Constrained random.
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] op;
            int          mode;
            op   = {$urandom, $urandom};
            mode = int'($urandom % 4);
            if (mode == 1)
                op[62:52] = 11'(1020 + ($urandom % 100));
            else if (mode == 2)
                op[62:52] = 11'd0;
            else if (mode == 3) begin
                op[62:52] = 11'(1023 + ($urandom % 32));
                if ($urandom % 2 == 1) op[31:0] = '0;
            end
            if (mode == 2 && ($urandom % 8 == 0)) op[51:0] = '0;
            run(op, 1'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule